// File: doc/BRIEF.md
# Bit Error Tester Receive Status and Sticky Flags

This block gathers the receive-side condition of a bit error rate tester into two words. The first is a live status word: whether the pattern checker is out of lock, whether the bit errors counted since the last counter update are nonzero, and whether a requested counter update has completed. The second is a word of sticky flags. Each flag records one kind of event and holds it until software writes a 1 to that flag's position.

The block counts single-bit error pulses in a running counter that saturates. A rising edge on the update request level copies the running count into a holding register and restarts the running count. Software raises the request, waits for the update-done status, reads the held count, and then drops the request. Dropping the request forces the done status low.

Top module: `bert_stat_flags`

## Requirements
- R1: While reset is asserted, and after reset is released, `stat`, `latch` and `held_cnt` are all zero until an input event changes them.
- R2: `stat[0]` (out of lock) equals the value of `oos_in` sampled at the previous clock edge.
- R3: `latch[0]` is set at the edge where `stat[0]` changes value, in either direction.
- R4: `latch[2]` is set at the edge that follows any cycle in which `bit_err` is high.
- R5: When `upd_req` is high in a cycle where it was low in the cycle before, the next edge loads `held_cnt` with the running count of errors seen before that cycle. The running count restarts at 1 if `bit_err` is high in that cycle, and at 0 otherwise.
- R6: With the default saturate option, the running count stops at 2^CNT_W-1 and does not wrap.
- R7: `stat[1]` is 1 exactly when the running count is nonzero, so it returns to 0 at an update edge that sees no error.
- R8: `latch[1]` is set at the edge where `stat[1]` goes from 0 to 1.
- R9: `stat[2]` is set at the edge after an `upd_done` pulse. It is cleared at the edge after a cycle in which `upd_req` is low and was high in the cycle before, and this clearing takes priority over a done pulse in that cycle.
- R10: `latch[3]` is set at the edge where `stat[2]` goes from 0 to 1.
- R11: A cycle with `clr_wr` high clears, at the next edge, each `latch` bit whose `clr_mask` bit is 1. It leaves the other bits unchanged.
- R12: If a set event for a `latch` bit occurs in the same cycle as a clear of that bit, the bit is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oos_in | input | 1 | Pattern checker out-of-lock level |
| bit_err | input | 1 | One-cycle pulse per detected bit error |
| upd_req | input | 1 | Counter update request level |
| upd_done | input | 1 | One-cycle pulse when an update completes |
| clr_wr | input | 1 | Write strobe for clearing sticky flags |
| clr_mask | input | 4 | Sticky flags to clear (1 clears) |
| stat | output | 3 | Live status: bit2 update done, bit1 count nonzero, bit0 out of lock |
| latch | output | 4 | Sticky flags: bit3 update, bit2 bit error, bit1 count nonzero, bit0 lock change |
| held_cnt | output | CNT_W | Error count captured at the last update |

## Verification
Random stimulus with a fixed seed mixes sparse error pulses, occasional lock toggles, request toggles and done pulses, and random clear writes. Over many cycles this separates the rising-edge flags from the any-change flag and from the event-pulse flag. Directed runs cover the cases that random stimulus reaches only rarely. A long burst of errors with no update exposes wrap versus saturation. An error in the same cycle as a clear shows whether set beats clear. A done pulse together with the request's falling edge shows whether the fall takes priority. An error in the update cycle itself shows which interval that error is counted in.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
   localparam int unsigned NUM_ST = 3;
   localparam int unsigned NUM_LT = 4;
   localparam int unsigned ST_OOS = 0;
   localparam int unsigned ST_NZ  = 1;
   localparam int unsigned ST_UPD = 2;

   // sticky event vector, bit order matches the latch word
   typedef struct packed {
      logic upd;
      logic err;
      logic nz;
      logic oos;
   } lt_ev_t;
endpackage

// File: rtl/bsf_err_count.sv
module bsf_err_count #(
   parameter int unsigned CNT_W  = 24,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err,
   input  logic             snap,
   output logic [CNT_W-1:0] run_cnt,
   output logic [CNT_W-1:0] held_cnt,
   output logic             nz_next
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] inc_val;
   logic [CNT_W-1:0] run_nxt;

   generate
      if (SAT_EN) begin : g_sat
         always_comb inc_val = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + CNT_ONE;
      end else begin : g_wrap
         always_comb inc_val = run_cnt + CNT_ONE;
      end
   endgenerate

   always_comb begin
      if (snap)      run_nxt = err ? CNT_ONE : '0;
      else if (err)  run_nxt = inc_val;
      else           run_nxt = run_cnt;
   end

   assign nz_next = (run_nxt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         held_cnt <= '0;
      end else begin
         run_cnt <= run_nxt;
         if (snap) held_cnt <= run_cnt;
      end
   end
endmodule

// File: rtl/bsf_upd_track.sv
module bsf_upd_track (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic done,
   output logic req_rise,
   output logic req_fall,
   output logic st,
   output logic st_rise
);
   logic req_q;
   logic st_nxt;

   assign req_rise = req & ~req_q;
   assign req_fall = ~req & req_q;

   always_comb begin
      if (req_fall)  st_nxt = 1'b0;
      else if (done) st_nxt = 1'b1;
      else           st_nxt = st;
   end

   assign st_rise = st_nxt & ~st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         st    <= 1'b0;
      end else begin
         req_q <= req;
         st    <= st_nxt;
      end
   end
endmodule

// File: rtl/bsf_sticky.sv
module bsf_sticky #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)                      q[i] <= 1'b0;
            else if (set[i])                 q[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])  q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/bert_stat_flags.sv
module bert_stat_flags
   import bsf_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 oos_in,
   input  logic                 bit_err,
   input  logic                 upd_req,
   input  logic                 upd_done,
   input  logic                 clr_wr,
   input  logic [NUM_LT-1:0]    clr_mask,
   output logic [NUM_ST-1:0]    stat,
   output logic [NUM_LT-1:0]    latch,
   output logic [CNT_W-1:0]     held_cnt
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("bert_stat_flags: CNT_W must be at least 2");
      end
   endgenerate

   logic             oos_q;
   logic             req_rise;
   logic             req_fall;
   logic             upd_st;
   logic             upd_rise;
   logic [CNT_W-1:0] run_cnt;
   logic             nz_next;
   logic             nz_now;
   lt_ev_t           ev;

   always_ff @(posedge clk) begin
      if (!rst_n) oos_q <= 1'b0;
      else        oos_q <= oos_in;
   end

   bsf_upd_track u_upd (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (upd_req),
      .done     (upd_done),
      .req_rise (req_rise),
      .req_fall (req_fall),
      .st       (upd_st),
      .st_rise  (upd_rise)
   );

   bsf_err_count #(.CNT_W(CNT_W), .SAT_EN(SAT_EN)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .err      (bit_err),
      .snap     (req_rise),
      .run_cnt  (run_cnt),
      .held_cnt (held_cnt),
      .nz_next  (nz_next)
   );

   assign nz_now = (run_cnt != '0);

   always_comb begin
      ev.oos = oos_in ^ oos_q;
      ev.nz  = nz_next & ~nz_now;
      ev.err = bit_err;
      ev.upd = upd_rise;
   end

   bsf_sticky #(.N(NUM_LT)) u_lt (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (ev),
      .clr_wr   (clr_wr),
      .clr_mask (clr_mask),
      .q        (latch)
   );

   always_comb begin
      stat         = '0;
      stat[ST_OOS] = oos_q;
      stat[ST_NZ]  = nz_now;
      stat[ST_UPD] = upd_st;
   end
endmodule

// File: rtl/bsf_chk.sv
module bsf_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             oos_in,
   input logic             bit_err,
   input logic             clr_wr,
   input logic [3:0]       clr_mask,
   input logic [2:0]       stat,
   input logic [3:0]       latch,
   input logic [CNT_W-1:0] held_cnt,
   input logic [CNT_W-1:0] run_cnt,
   input logic             req_rise,
   input logic             req_fall
);
   p_oos_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stat[0] == $past(oos_in));

   p_oos_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && (stat[0] != $past(stat[0])) |-> latch[0]);

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(bit_err) |-> latch[2]);

   p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(req_rise) |-> held_cnt == $past(run_cnt));

   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ($past(run_cnt) == {CNT_W{1'b1}}) && !$past(req_rise)
      |-> run_cnt == {CNT_W{1'b1}});

   p_nz_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $rose(stat[1]) |-> latch[1]);

   p_fall_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(req_fall) |-> !stat[2]);

   p_upd_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $rose(stat[2]) |-> latch[3]);

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(clr_wr) && $past(clr_mask[2]) && !$past(bit_err) |-> !latch[2]);

   p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(clr_wr) && $past(clr_mask[2]) && $past(bit_err) |-> latch[2]);
endmodule

bind bert_stat_flags bsf_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .oos_in   (oos_in),
   .bit_err  (bit_err),
   .clr_wr   (clr_wr),
   .clr_mask (clr_mask),
   .stat     (stat),
   .latch    (latch),
   .held_cnt (held_cnt),
   .run_cnt  (run_cnt),
   .req_rise (req_rise),
   .req_fall (req_fall)
);

// File: tb/sim_bert_stat_flags.sv
module sim_bert_stat_flags;
   localparam int unsigned W = 4;
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic oos_in = 1'b0, bit_err = 1'b0, upd_req = 1'b0, upd_done = 1'b0, clr_wr = 1'b0;
   logic [3:0] clr_mask = 4'h0;
   logic [2:0] stat;
   logic [3:0] latch;
   logic [W-1:0] held_cnt;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // bench model state
   logic m_oos = 0, m_rq = 0, m_upd = 0;
   logic [W-1:0] m_run = '0, m_held = '0;
   logic [3:0] m_lt = '0;

   always #5 clk = ~clk;

   bert_stat_flags #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .oos_in(oos_in), .bit_err(bit_err),
      .upd_req(upd_req), .upd_done(upd_done), .clr_wr(clr_wr),
      .clr_mask(clr_mask), .stat(stat), .latch(latch), .held_cnt(held_cnt)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] next_run(logic [W-1:0] r, logic e, logic rise);
      if (rise) return e ? W'(1) : W'(0);
      if (e) return (r == MAXV) ? r : r + W'(1);
      return r;
   endfunction

   // advance the model by one edge using the inputs now applied
   task automatic model_edge();
      logic rise, fall, nz, nz_n, ev_nz, ev_oos, upd_n, ev_upd;
      logic [W-1:0] run_n;
      logic [3:0] ev;
      rise   = upd_req & ~m_rq;
      fall   = ~upd_req & m_rq;
      run_n  = next_run(m_run, bit_err, rise);
      nz     = (m_run != '0);
      nz_n   = (run_n != '0);
      ev_nz  = nz_n & ~nz;
      ev_oos = oos_in ^ m_oos;
      upd_n  = fall ? 1'b0 : (upd_done ? 1'b1 : m_upd);
      ev_upd = upd_n & ~m_upd;
      ev     = {ev_upd, bit_err, ev_nz, ev_oos};
      m_lt   = (m_lt & ~(clr_wr ? clr_mask : 4'h0)) | ev;
      if (rise) m_held = m_run;
      m_run  = run_n;
      m_oos  = oos_in;
      m_rq   = upd_req;
      m_upd  = upd_n;
   endtask

   task automatic compare_all();
      chk("R2 stat[0]", int'(stat[0]), int'(m_oos));
      chk("R7 stat[1]", int'(stat[1]), int'(m_run != '0));
      chk("R9 stat[2]", int'(stat[2]), int'(m_upd));
      chk("R5 held_cnt", int'(held_cnt), int'(m_held));
      chk("R3 latch[0]", int'(latch[0]), int'(m_lt[0]));
      chk("R8 latch[1]", int'(latch[1]), int'(m_lt[1]));
      chk("R4 latch[2]", int'(latch[2]), int'(m_lt[2]));
      chk("R10 latch[3]", int'(latch[3]), int'(m_lt[3]));
   endtask

   // inputs are applied just after a falling edge; outputs checked at the next one
   task automatic cyc(input logic o, input logic e, input logic rq, input logic dn,
                      input logic cw, input logic [3:0] cm);
      oos_in = o; bit_err = e; upd_req = rq; upd_done = dn; clr_wr = cw; clr_mask = cm;
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 stat", int'(stat), 0);
      chk("R1 latch", int'(latch), 0);
      chk("R1 held_cnt", int'(held_cnt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 stat after release", int'(stat), 0);
      chk("R1 latch after release", int'(latch), 0);

      // R6: saturation with an error burst, then snapshot
      for (int i = 0; i < 20; i++) cyc(m_oos, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
      cyc(m_oos, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
      chk("R6 held saturates", int'(held_cnt), int'(MAXV));
      chk("R7 stat[1] cleared by update", int'(stat[1]), 0);

      // R9: done pulse sets status, fall with done clears it
      cyc(m_oos, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
      chk("R9 done sets status", int'(stat[2]), 1);
      chk("R10 latch[3] set", int'(latch[3]), 1);
      cyc(m_oos, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      chk("R9 fall beats done", int'(stat[2]), 0);

      // R11: clear all with no events
      cyc(m_oos, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
      chk("R11 all cleared", int'(latch), 0);

      // R12: error together with clearing bit 2
      cyc(m_oos, 1'b1, 1'b0, 1'b0, 1'b1, 4'h4);
      chk("R12 set beats clear", int'(latch[2]), 1);
      chk("R8 latch[1] on nonzero rise", int'(latch[1]), 1);
      // R11: partial clear leaves other bits
      cyc(m_oos, 1'b0, 1'b0, 1'b0, 1'b1, 4'h4);
      chk("R11 bit2 cleared", int'(latch[2]), 0);
      chk("R11 bit1 kept", int'(latch[1]), 1);

      // R3: lock loss and regain both latch
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      chk("R3 latch on rise", int'(latch[0]), 1);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'h1);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      chk("R3 latch on fall", int'(latch[0]), 1);

      // R5: error in the update cycle goes to the new interval
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
      chk("R5 held excludes update-cycle error", int'(held_cnt), int'(m_held));
      chk("R5 stat[1] kept by update-cycle error", int'(stat[1]), 1);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic o, rq;
         o  = (($urandom % 16) == 0) ? ~oos_in : oos_in;
         rq = (($urandom % 10) == 0) ? ~upd_req : upd_req;
         cyc(o, ($urandom % 4) == 0, rq, ($urandom % 8) == 0,
             ($urandom % 6) == 0, 4'($urandom));
      end

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule